// File: doc/BRIEF.md
# Serial Boot-Configuration Register Slave

This block is a serial-peripheral slave (clock idles low, data captured on the rising clock edge, chip select active low) that holds one 32-bit boot-configuration word. A host reads the word with opcode 0x14 and replaces it with opcode 0x15. A replacement needs an earlier 0x06 (write-enable) transaction. It runs as a self-timed update with an erase phase and a program phase, and while it runs a host may poll a status byte with opcode 0x05. The serial pins are brought into the system clock domain through a synchronizer. All decoding, counting and timing therefore runs on the system clock, which must be several times faster than the serial clock.

The word travels least-significant byte first, and each byte goes most-significant bit first. This order applies in both directions. A write takes effect only when chip select rises straight after the 32nd data bit. Two test inputs force the erase phase or the program phase to fail, so that the two error flags can be observed.

Serial states: `ST_IDLE` (deselected), `ST_OPCODE` (collecting 8 opcode bits), `ST_WREN`, `ST_STAT`, `ST_READ`, `ST_WDATA` (collecting data bits), `ST_WFULL` (exactly 32 bits held) and `ST_DROP` (ignore until deselect). The transitions are as follows:
- `ST_IDLE`→`ST_OPCODE` on the chip-select fall.
- `ST_OPCODE`→ a decoded state on the 8th rising clock.
- `ST_WDATA`→`ST_WFULL` on the 32nd data bit.
- `ST_WFULL`→`ST_DROP` on any extra clock.
- Any state →`ST_IDLE` on the chip-select rise.

Update states: `UP_IDLE`→`UP_ERASE` on an accepted write. `UP_ERASE`→`UP_PROGRAM` when the erase time expires without failure, or →`UP_IDLE` when the erase fails. `UP_PROGRAM`→`UP_IDLE` when the program time expires.

Top module: `bcfg_spi_slave`

## Requirements
- R1: After opcode 0x14, SO presents the word as byte 0 (bits 7:0), then byte 1, byte 2 and byte 3, each byte most-significant bit first. SO changes after falling SCK, and SI is sampled on rising SCK.
- R2: While chip select stays low during a 0x14 read, the whole word is sent again for every further 32 clocks.
- R3: so_oe is 0 while chip select is high, while the opcode is shifted in, and during the whole of a 0x15 transaction.
- R4: Opcode 0x06 sets the write-enable latch when chip select rises. Opcode 0x15 is accepted only when that latch is set, and otherwise the word is unchanged. Write data is taken in the same byte and bit order as R1.
- R5: A write runs only if chip select rises after exactly 32 data bits. With fewer or more bits the word, the write-enable latch and the busy flag stay unchanged.
- R6: An accepted write holds the busy flag at 1 for ERASE_CYCLES+PROGRAM_CYCLES system clocks after the chip-select rise, then returns it to 0. At that point the write-enable latch is cleared.
- R7: Opcode 0x05 returns a status byte with busy in bit 0, write-enable in bit 1, erase error in bit 5 and program error in bit 6, and 0 in the other bits. The byte repeats every 8 clocks and can be read during an update.
- R8: fail_erase high at the end of the erase phase sets the erase error and skips programming. fail_program high at the end of the program phase sets the program error. In both cases the word is kept. Both flags clear when the next write starts.
- R9: While busy, every opcode except 0x05 is ignored and so_oe stays 0.
- R10: After reset the word equals RESET_VALUE, the status byte is 0x00 and so_oe is 0.
- R11: An unknown opcode is ignored until chip select rises, and SO stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO (0 = high impedance) |
| fail_erase | input | 1 | Test input: erase phase fails |
| fail_program | input | 1 | Test input: program phase fails |

## Verification
The checker watches these rules on every cycle: SO is enabled during an update only for a status read, the write-enable latch is cleared when busy falls, the word never changes outside an update, the two error flags are never set together, and an update starts only with the latch set. Only the scenarios can show the serial byte and bit order, the repeat of the word and of the status byte, and the framing aborts with too few or too many bits. They also cover the ignored opcodes and the flag values after each injected failure, all of which depend on a whole transaction rather than on one cycle.

// File: rtl/bcfg_pkg.sv
`timescale 1ns/1ps
package bcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WREN,
        ST_STAT,
        ST_READ,
        ST_WDATA,
        ST_WFULL,
        ST_DROP
    } spi_state_t;

    typedef enum logic [1:0] {
        UP_IDLE,
        UP_ERASE,
        UP_PROGRAM
    } upd_state_t;

    localparam logic [7:0] OPC_READ   = 8'h14;
    localparam logic [7:0] OPC_WRITE  = 8'h15;
    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_STATUS = 8'h05;

    localparam int STAT_BUSY = 0;
    localparam int STAT_WEL  = 1;
    localparam int STAT_EERR = 5;
    localparam int STAT_PERR = 6;

endpackage

// File: rtl/bcfg_sync.sv
`timescale 1ns/1ps
module bcfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic si_s
);
    // bit 2 = chip select, bit 1 = serial clock, bit 0 = data
    localparam logic [2:0] IDLE_LEVELS = 3'b100;

    logic [2:0] stage [STAGES];
    logic [2:0] prev;
    logic [2:0] cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= IDLE_LEVELS;
            prev <= IDLE_LEVELS;
        end else begin
            stage[0] <= {cs_n, sck, si};
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
            prev <= stage[STAGES-1];
        end
    end

    assign cur      = stage[STAGES-1];
    assign sck_rise = cur[1] & ~prev[1] & ~cur[2];
    assign sck_fall = ~cur[1] & prev[1] & ~cur[2];
    assign cs_fall  = ~cur[2] & prev[2];
    assign cs_rise  = cur[2] & ~prev[2];
    assign si_s     = cur[0];

endmodule

// File: rtl/bcfg_spi_fsm.sv
`timescale 1ns/1ps
module bcfg_spi_fsm
    import bcfg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OPC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              si_s,
    input  logic              busy,
    input  logic              wel,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic [7:0]        status_byte,
    output logic              so,
    output logic              so_oe,
    output logic              set_wel,
    output logic              start_write,
    output logic [DATA_W-1:0] wdata,
    output spi_state_t        state
);
    localparam int NBYTES = DATA_W / 8;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_OPC  = CNT_W'(OPC_W - 1);

    spi_state_t        state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  out_cnt;
    logic [DATA_W-1:0] shreg;
    logic [7:0]        stat_snap;
    logic              so_q;
    logic [OPC_W-1:0]  opcode;
    logic              opc_done;
    logic [DATA_W-1:0] rd_ser;
    logic [CNT_W-1:0]  rd_idx;
    logic [2:0]        st_idx;

    // wire order <-> register order: byte 0 travels first
    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] w);
        for (int b = 0; b < NBYTES; b++)
            swap_bytes[8*b +: 8] = w[8*(NBYTES-1-b) +: 8];
    endfunction

    assign opcode   = {shreg[OPC_W-2:0], si_s};
    assign opc_done = sck_rise && (state == ST_OPCODE) && (bit_cnt == LAST_OPC);
    assign rd_ser   = swap_bytes(cfg_word);
    assign rd_idx   = LAST_DATA - out_cnt;
    assign st_idx   = 3'd7 - out_cnt[2:0];

    // next-state logic
    always_comb begin
        state_n = state;
        if (cs_rise) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (cs_fall) state_n = ST_OPCODE;
                ST_OPCODE: begin
                    if (opc_done) begin
                        if (busy && opcode != OPC_STATUS) state_n = ST_DROP;
                        else begin
                            unique case (opcode)
                                OPC_WREN:   state_n = ST_WREN;
                                OPC_STATUS: state_n = ST_STAT;
                                OPC_READ:   state_n = ST_READ;
                                OPC_WRITE:  state_n = wel ? ST_WDATA : ST_DROP;
                                default:    state_n = ST_DROP;
                            endcase
                        end
                    end
                end
                ST_WDATA:  if (sck_rise && bit_cnt == LAST_DATA) state_n = ST_WFULL;
                ST_WFULL:  if (sck_rise) state_n = ST_DROP;
                ST_WREN, ST_STAT, ST_READ, ST_DROP: state_n = state;
                default:   state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // shifting and counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            out_cnt   <= '0;
            shreg     <= '0;
            stat_snap <= '0;
            so_q      <= 1'b0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
            out_cnt <= '0;
        end else begin
            if (sck_rise) begin
                shreg <= {shreg[DATA_W-2:0], si_s};
                if (opc_done)
                    bit_cnt <= '0;
                else if (state == ST_OPCODE || state == ST_WDATA)
                    bit_cnt <= bit_cnt + 1'b1;
            end
            if (sck_fall) begin
                if (state == ST_READ) begin
                    so_q    <= rd_ser[rd_idx];
                    out_cnt <= out_cnt + 1'b1;
                end else if (state == ST_STAT) begin
                    if (out_cnt[2:0] == 3'd0) begin
                        stat_snap <= status_byte;
                        so_q      <= status_byte[7];
                    end else begin
                        so_q <= stat_snap[st_idx];
                    end
                    out_cnt <= out_cnt + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        so          = so_q;
        so_oe       = (state == ST_READ) || (state == ST_STAT);
        set_wel     = (state == ST_WREN) && cs_rise;
        start_write = (state == ST_WFULL) && cs_rise;
        wdata       = swap_bytes(shreg);
    end

endmodule

// File: rtl/bcfg_update.sv
`timescale 1ns/1ps
module bcfg_update
    import bcfg_pkg::*;
#(
    parameter int              DATA_W         = 32,
    parameter int              ERASE_CYCLES   = 600,
    parameter int              PROGRAM_CYCLES = 400,
    parameter logic [DATA_W-1:0] RESET_VALUE  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_wel,
    input  logic              fail_erase,
    input  logic              fail_program,
    output logic [DATA_W-1:0] cfg_word,
    output logic              busy,
    output logic              wel,
    output logic              erase_err,
    output logic              program_err,
    output upd_state_t        state
);
    localparam int MAXC  = (ERASE_CYCLES > PROGRAM_CYCLES) ? ERASE_CYCLES : PROGRAM_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROGRAM_CYCLES - 1);

    upd_state_t        state_n;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] pend;
    logic              erase_end;
    logic              prog_end;

    assign erase_end = (state == UP_ERASE) && (cnt == ERASE_LAST);
    assign prog_end  = (state == UP_PROGRAM) && (cnt == PROG_LAST);

    always_comb begin
        state_n = state;
        unique case (state)
            UP_IDLE:    if (start) state_n = UP_ERASE;
            UP_ERASE:   if (erase_end) state_n = fail_erase ? UP_IDLE : UP_PROGRAM;
            UP_PROGRAM: if (prog_end) state_n = UP_IDLE;
            default:    state_n = UP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= UP_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            pend        <= '0;
            cfg_word    <= RESET_VALUE;
            wel         <= 1'b0;
            erase_err   <= 1'b0;
            program_err <= 1'b0;
        end else begin
            if (state != state_n) cnt <= '0;
            else if (state != UP_IDLE) cnt <= cnt + 1'b1;

            if (state == UP_IDLE && start) begin
                pend        <= wdata;
                erase_err   <= 1'b0;
                program_err <= 1'b0;
            end
            if (erase_end && fail_erase) erase_err <= 1'b1;
            if (prog_end) begin
                if (fail_program) program_err <= 1'b1;
                else              cfg_word    <= pend;
            end

            if ((erase_end && fail_erase) || prog_end) wel <= 1'b0;
            else if (set_wel && state == UP_IDLE)      wel <= 1'b1;
        end
    end

    always_comb busy = (state != UP_IDLE);

endmodule

// File: rtl/bcfg_spi_slave.sv
`timescale 1ns/1ps
module bcfg_spi_slave
    import bcfg_pkg::*;
#(
    parameter int                DATA_W         = 32,
    parameter int                SYNC_STAGES    = 2,
    parameter int                ERASE_CYCLES   = 600,
    parameter int                PROGRAM_CYCLES = 400,
    parameter logic [DATA_W-1:0] RESET_VALUE    = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic so,
    output logic so_oe,
    input  logic fail_erase,
    input  logic fail_program
);
    logic              sck_rise, sck_fall, cs_fall, cs_rise, si_s;
    logic              busy, wel, erase_err, program_err;
    logic              set_wel, start_write;
    logic [DATA_W-1:0] cfg_word, wdata;
    logic [7:0]        status_byte;
    spi_state_t        spi_state;
    upd_state_t        upd_state;

    always_comb begin
        status_byte            = '0;
        status_byte[STAT_BUSY] = busy;
        status_byte[STAT_WEL]  = wel;
        status_byte[STAT_EERR] = erase_err;
        status_byte[STAT_PERR] = program_err;
    end

    bcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .si_s(si_s)
    );

    bcfg_spi_fsm #(.DATA_W(DATA_W), .OPC_W(8)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .si_s(si_s),
        .busy(busy), .wel(wel), .cfg_word(cfg_word), .status_byte(status_byte),
        .so(so), .so_oe(so_oe), .set_wel(set_wel), .start_write(start_write),
        .wdata(wdata), .state(spi_state)
    );

    bcfg_update #(
        .DATA_W(DATA_W), .ERASE_CYCLES(ERASE_CYCLES),
        .PROGRAM_CYCLES(PROGRAM_CYCLES), .RESET_VALUE(RESET_VALUE)
    ) u_upd (
        .clk(clk), .rst_n(rst_n), .start(start_write), .wdata(wdata),
        .set_wel(set_wel), .fail_erase(fail_erase), .fail_program(fail_program),
        .cfg_word(cfg_word), .busy(busy), .wel(wel),
        .erase_err(erase_err), .program_err(program_err), .state(upd_state)
    );

endmodule

// File: rtl/bcfg_checker.sv
`timescale 1ns/1ps
module bcfg_checker
    import bcfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              wel,
    input logic              erase_err,
    input logic              program_err,
    input logic              so_oe,
    input logic [DATA_W-1:0] cfg_word,
    input spi_state_t        spi_state
);
    AST_BUSY_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && so_oe) |-> (spi_state == ST_STAT)); // R9
    AST_WEL_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R6
    AST_WORD_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(cfg_word)); // R5
    AST_ERRORS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_err, program_err})); // R8
    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wel); // R4
endmodule

bind bcfg_spi_slave bcfg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel),
    .erase_err(erase_err), .program_err(program_err), .so_oe(so_oe),
    .cfg_word(cfg_word), .spi_state(spi_state)
);

// File: tb/bcfg_spi_slave_test.sv
`timescale 1ns/1ps
module bcfg_spi_slave_test;
    localparam int          HALF = 160;
    localparam logic [31:0] RV   = 32'hA5C3_1E07;
    localparam int          ER   = 600;
    localparam int          PR   = 400;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic fail_erase = 1'b0, fail_program = 1'b0;
    logic so, so_oe;
    int checks = 0, fails = 0;

    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t expq[$];

    bcfg_spi_slave #(.ERASE_CYCLES(ER), .PROGRAM_CYCLES(PR), .RESET_VALUE(RV)) uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .fail_erase(fail_erase), .fail_program(fail_program)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: assemble bytes from SO and compare against the scoreboard
    logic [7:0] mon_sh = '0;
    int mon_n = 0;
    always @(negedge cs_n) mon_n = 0;
    always @(posedge sck) begin
        if (!cs_n && so_oe) begin
            mon_sh = {mon_sh[6:0], so};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (expq.size() == 0) check(1'b0, "unexpected byte", {24'h0, mon_sh}, 32'h0);
                else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(mon_sh == e.val, e.req, {24'h0, mon_sh}, {24'h0, e.val});
                end
            end
        end
    end

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
        #HALF;
    endtask

    task automatic cs_end();
        #HALF;
        cs_n = 1'b1;
        #(2*HALF);
    endtask

    task automatic bit_x(input logic b, input bit chk_off, input string req);
        si = b;
        #HALF;
        sck = 1'b1;
        if (chk_off) check(so_oe == 1'b0, req, {31'h0, so_oe}, 32'h0);
        #HALF;
        sck = 1'b0;
    endtask

    task automatic byte_x(input logic [7:0] v, input bit chk_off, input string req);
        for (int i = 7; i >= 0; i--) bit_x(v[i], chk_off, req);
    endtask

    task automatic do_status(input logic [7:0] exp, input string req, input int n);
        cs_begin();
        byte_x(8'h05, 1'b1, "R3 opcode phase");
        for (int k = 0; k < n; k++) expq.push_back('{exp, req});
        for (int k = 0; k < n; k++) byte_x(8'h00, 1'b0, "");
        cs_end();
    endtask

    task automatic do_read(input logic [31:0] w, input string req, input int nwords);
        cs_begin();
        byte_x(8'h14, 1'b1, "R3 opcode phase");
        for (int k = 0; k < nwords; k++)
            for (int b = 0; b < 4; b++) expq.push_back('{w[8*b +: 8], req});
        for (int k = 0; k < 4*nwords; k++) byte_x(8'h00, 1'b0, "");
        cs_end();
    endtask

    task automatic do_ignored(input logic [7:0] opc, input string req);
        cs_begin();
        byte_x(opc, 1'b1, req);
        byte_x(8'hFF, 1'b1, req);
        byte_x(8'h00, 1'b1, req);
        cs_end();
    endtask

    task automatic do_wren();
        cs_begin();
        byte_x(8'h06, 1'b1, "R3 opcode phase");
        cs_end();
    endtask

    task automatic do_write(input logic [31:0] w, input int nbits);
        logic [31:0] ser;
        ser = {w[7:0], w[15:8], w[23:16], w[31:24]};
        cs_begin();
        byte_x(8'h15, 1'b1, "R3 opcode phase");
        for (int i = 0; i < nbits; i++) bit_x((i < 32) ? ser[31-i] : 1'b0, 1'b1, "R3 write phase");
        cs_end();
    endtask

    task automatic wait_update();
        repeat (ER + PR + 100) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(so_oe == 1'b0, "R10 so_oe after reset", {31'h0, so_oe}, 32'h0);
        do_status(8'h00, "R10 status after reset", 1);
        do_read(RV, "R10 R1 reset word", 1);
        do_read(RV, "R2 repeated word", 2);
        do_write(32'hDEAD_BEEF, 32);                      // no write enable: R4
        do_status(8'h00, "R4 write ignored without enable", 1);
        do_read(RV, "R4 word unchanged", 1);
        do_wren();
        do_status(8'h02, "R7 R4 enable latch set", 2);
        do_write(32'h0BAD_0BAD, 24);                      // too short: R5
        do_status(8'h02, "R5 short frame aborted", 1);
        do_write(32'h0BAD_0BAD, 33);                      // too long: R5
        do_status(8'h02, "R5 long frame aborted", 1);
        do_read(RV, "R5 word unchanged after aborts", 1);
        do_write(32'h1234_5678, 32);
        do_status(8'h03, "R6 R7 busy during update", 2);
        do_ignored(8'h14, "R9 read ignored while busy");
        wait_update();
        do_status(8'h00, "R6 busy and enable cleared", 1);
        do_read(32'h1234_5678, "R4 R1 new word", 1);
        do_ignored(8'h9F, "R11 unknown opcode");
        do_wren();
        fail_erase = 1'b1;
        do_write(32'h5555_AAAA, 32);
        wait_update();
        fail_erase = 1'b0;
        do_status(8'h20, "R8 erase error", 1);
        do_read(32'h1234_5678, "R8 word kept after erase error", 1);
        do_wren();
        fail_program = 1'b1;
        do_write(32'h6666_9999, 32);
        wait_update();
        fail_program = 1'b0;
        do_status(8'h40, "R8 program error", 1);
        do_read(32'h1234_5678, "R8 word kept after program error", 1);
        do_wren();
        do_write(32'hC001_D00D, 32);
        wait_update();
        do_status(8'h00, "R8 flags cleared by new write", 1);
        do_read(32'hC001_D00D, "R1 final word", 1);
        check(expq.size() == 0, "scoreboard drained", expq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule